// File: doc/BRIEF.md
# Flash Program/Erase Status Word Generator

This block builds the byte a parallel NOR flash drives onto its data lines when the host reads it during an embedded program or erase. It also covers reads while that operation is suspended and reads after it has failed. The embedded algorithm supplies the state of the operation: busy, whether it is an erase, suspended, error events, a low programming-supply flag and the polling-mode setting. The block tracks the two toggle bits and the sticky failure and completion state. On every read strobe it registers either a status byte or a flag that tells the read path to return the true array word.

The polling-mode input selects one of two encodings for bit 7. With the input low, bit 7 carries the inverse of the programmed data bit, or 0 during an erase, and the device returns to array reads on its own after success. With the input high, bit 7 reads 0 while the operation runs and 1 once it has ended. The completed status is then held until an exit command.

Addresses are grouped into sectors of 2^SECT_LSB words. During an erase, "the target region" is the target address's sector. During a program, it is the single target word.

Top module: `flashstat_gen`

## Requirements
- R1: After reset, `status_out` is 0x00 and `use_array` is 1.
- R2: With `poll_mode` = 0 and a non-suspended operation running, a read returns bit 7 equal to the inverse of `tgt_data[7]` during a program and 0 during an erase.
- R3: With `poll_mode` = 1, bit 7 reads 0 while a non-suspended operation runs and reads 1 in the held state after the operation has ended.
- R4: While an operation runs unsuspended, bit 6 inverts on each successive read. Once `busy` is low, successive reads return the same bit 6.
- R5: Bit 5 becomes 1 and stays 1 after `err_limit` or `err_protect` is seen while `busy` is 1, or after `prog_start` of a program whose `tgt_data` has a 1 where `old_word` has a 0. `err_limit` and `err_protect` have no effect while `busy` is 0.
- R6: Bit 3 becomes 1 and stays 1 after `vpp_low` is seen while `busy` is 1.
- R7: Once bit 5 or bit 3 is set, reads return status (`use_array` = 0) until `exit_cmd` is given while `busy` is 0. `exit_cmd` while `busy` is 1 has no effect.
- R8: After a successful operation, `use_array` returns to 1 when `busy` falls if `poll_mode` was 0 throughout. If `poll_mode` was 1 during the operation, status is held until `exit_cmd`.
- R9: While suspended, a read inside the target region returns bit 7 = 1 and bit 6 = 1. A read outside the region returns `use_array` = 1 and `status_out` = 0x00.
- R10: Bit 2 reads 1 during a program. During an erase, whether running or suspended, it inverts after every read that falls in the sector being erased.
- R11: Bits 4, 1 and 0 of `status_out` are always 0.
- R12: `status_out` and `use_array` change only on a clock edge at which `rd_strobe` is 1, and take the value for that read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Embedded program or erase in progress (also high while suspended) |
| op_erase | input | 1 | 1: current operation is an erase, 0: a program |
| suspended | input | 1 | Current operation is suspended |
| poll_mode | input | 1 | Bit-7 encoding select and hold-after-success enable |
| err_limit | input | 1 | Pulse-count limit exceeded |
| err_protect | input | 1 | Target sector is protected |
| prog_start | input | 1 | Pulse: a program is being launched with `old_word` and `tgt_data` |
| old_word | input | DATA_W | Array content at the program target before programming |
| vpp_low | input | 1 | Programming supply too low for the operation |
| exit_cmd | input | 1 | Exit command decoded (leave status mode) |
| rd_strobe | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Address of the read |
| tgt_addr | input | ADDR_W | Address of the word being programmed or inside the sector being erased |
| tgt_data | input | DATA_W | Data being programmed |
| status_out | output | 8 | Registered status byte for the last read |
| use_array | output | 1 | 1: return the array word instead of `status_out` |

## Verification
The bench builds the block with a 12-bit address, 16-bit data and sectors of 256 words. With these values, random read and target addresses fall in the same sector often enough to exercise the toggle of bit 2 and suspended reads inside and outside the erased region. Random runs mix both polling modes, suspension, sticky errors and exit commands, and a reference model follows every cycle. Directed sequences pin down both encodings of bit 7, the exit ignored while busy, and the program that tries to raise a cleared bit.

// File: rtl/flashstat_pkg.sv
package flashstat_pkg;
    // Bit positions of the status byte (decoded by host polling software).
    localparam int B_POLL   = 7;
    localparam int B_TOG    = 6;
    localparam int B_FAIL   = 5;
    localparam int B_SUPPLY = 3;
    localparam int B_ETOG   = 2;

    // Sticky hold state kept between reads.
    typedef struct packed {
        logic fail;    // operation failed (limit, protection, illegal raise)
        logic supply;  // programming supply was too low
        logic done;    // completion held for the exit command
    } hold_t;
endpackage

// File: rtl/flashstat_sticky.sv
// flashstat_sticky: sticky failure and completion flags.
// Assumes exit_cmd is a decoded one-cycle command; it only acts when idle.
// Setting wins over clearing in the same cycle.
module flashstat_sticky
    import flashstat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              poll_mode,
    input  logic              err_limit,
    input  logic              err_protect,
    input  logic              prog_start,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic              vpp_low,
    input  logic              exit_cmd,
    output hold_t             hold
);
    logic clr;
    logic raise_bit;
    logic set_fail;
    logic set_supply;
    logic set_done;

    // Purpose: decode the set and clear conditions of the flags.
    always_comb begin
        clr        = exit_cmd && !busy;
        raise_bit  = |(~old_word & new_word);
        set_fail   = (busy && (err_limit || err_protect)) ||
                     (prog_start && !op_erase && raise_bit);
        set_supply = busy && vpp_low;
        set_done   = busy && poll_mode;
    end

    // Purpose: update the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else begin
            hold.fail   <= (hold.fail   && !clr) || set_fail;
            hold.supply <= (hold.supply && !clr) || set_supply;
            hold.done   <= (hold.done   && !clr) || set_done;
        end
    end
endmodule

// File: rtl/flashstat_toggle.sv
// flashstat_toggle: the two toggle bits advanced by reads.
// Assumes rd_strobe is one cycle per host read.
module flashstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic busy,
    input  logic suspended,
    input  logic op_erase,
    input  logic sec_hit,
    output logic tog_run,
    output logic tog_erase
);
    // Purpose: flip the run toggle on each read of a running operation,
    // and the erase toggle on each read of the sector being erased.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_run   <= 1'b0;
            tog_erase <= 1'b0;
        end else if (rd_strobe) begin
            if (busy && !suspended)
                tog_run <= !tog_run;
            if (busy && op_erase && sec_hit)
                tog_erase <= !tog_erase;
        end
    end
endmodule

// File: rtl/flashstat_compose.sv
// flashstat_compose: combinational choice between status and array data,
// and assembly of the status byte from the current state.
module flashstat_compose
    import flashstat_pkg::*;
(
    input  logic       busy,
    input  logic       suspended,
    input  logic       op_erase,
    input  logic       poll_mode,
    input  logic       in_region,
    input  logic       tgt_bit7,
    input  hold_t      hold,
    input  logic       tog_run,
    input  logic       tog_erase,
    output logic       show,
    output logic [7:0] word
);
    logic held;
    logic data_poll;

    // Purpose: select status or array and build the byte.
    always_comb begin
        held      = !busy && (hold.fail || hold.supply || hold.done);
        show      = busy ? (!suspended || in_region) : held;
        data_poll = op_erase ? 1'b0 : !tgt_bit7;
        word      = 8'h00;
        if (show) begin
            word[B_FAIL]   = hold.fail;
            word[B_SUPPLY] = hold.supply;
            if (busy && !suspended) begin
                word[B_POLL] = poll_mode ? 1'b0 : data_poll;
                word[B_TOG]  = tog_run;
                word[B_ETOG] = op_erase ? tog_erase : 1'b1;
            end else if (busy) begin
                word[B_POLL] = 1'b1;
                word[B_TOG]  = 1'b1;
                word[B_ETOG] = op_erase ? tog_erase : 1'b1;
            end else begin
                word[B_POLL] = poll_mode ? 1'b1 : data_poll;
                word[B_TOG]  = tog_run;
                word[B_ETOG] = tog_erase;
            end
        end
    end
endmodule

// File: rtl/flashstat_gen.sv
// flashstat_gen: status word generator for embedded program/erase reads.
// Assumes the embedded controller holds busy high from launch until the
// operation ends, including while suspended.
// Output is registered on each read strobe.
module flashstat_gen
    import flashstat_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              suspended,
    input  logic              poll_mode,
    input  logic              err_limit,
    input  logic              err_protect,
    input  logic              prog_start,
    input  logic [DATA_W-1:0] old_word,
    input  logic              vpp_low,
    input  logic              exit_cmd,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [7:0]        status_out,
    output logic              use_array
);
    hold_t      hold;
    logic       sec_hit;
    logic       in_region;
    logic       tog_run;
    logic       tog_erase;
    logic       show;
    logic [7:0] word;
    logic       hold_any;

    // Sector compare; a sector size at least the address space is one sector.
    generate
        if (SECT_LSB >= ADDR_W) begin : g_one_sector
            assign sec_hit = 1'b1;
        end else begin : g_sectors
            assign sec_hit = rd_addr[ADDR_W-1:SECT_LSB] == tgt_addr[ADDR_W-1:SECT_LSB];
        end
    endgenerate

    // Purpose: region is the sector for an erase, the word for a program.
    always_comb begin
        in_region = op_erase ? sec_hit : (rd_addr == tgt_addr);
        hold_any  = hold.fail || hold.supply;
    end

    flashstat_sticky #(.DATA_W(DATA_W)) u_sticky (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .poll_mode(poll_mode), .err_limit(err_limit), .err_protect(err_protect),
        .prog_start(prog_start), .old_word(old_word), .new_word(tgt_data),
        .vpp_low(vpp_low), .exit_cmd(exit_cmd), .hold(hold)
    );

    flashstat_toggle u_toggle (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .busy(busy),
        .suspended(suspended), .op_erase(op_erase), .sec_hit(sec_hit),
        .tog_run(tog_run), .tog_erase(tog_erase)
    );

    flashstat_compose u_compose (
        .busy(busy), .suspended(suspended), .op_erase(op_erase),
        .poll_mode(poll_mode), .in_region(in_region), .tgt_bit7(tgt_data[7]),
        .hold(hold), .tog_run(tog_run), .tog_erase(tog_erase),
        .show(show), .word(word)
    );

    // Purpose: capture the answer to each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_out <= 8'h00;
            use_array  <= 1'b1;
        end else if (rd_strobe) begin
            status_out <= word;
            use_array  <= !show;
        end
    end
endmodule

// File: rtl/flashstat_gen_chk.sv
// flashstat_gen_chk: properties of flashstat_gen, attached with bind.
module flashstat_gen_chk #(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              op_erase,
    input logic              suspended,
    input logic              poll_mode,
    input logic              exit_cmd,
    input logic              rd_strobe,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [DATA_W-1:0] tgt_data,
    input logic [7:0]        status_out,
    input logic              use_array,
    input logic              hold_any
);
    // R12
    hold_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(status_out) && $stable(use_array));

    // R11
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (status_out[4] == 1'b0) && (status_out[1] == 1'b0) && (status_out[0] == 1'b0));

    // R4
    run_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy && !suspended) ##1 (rd_strobe && busy && !suspended)
        |=> status_out[6] != $past(status_out[6]));

    // R2
    data_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy && !suspended && !poll_mode && !op_erase)
        |=> status_out[7] == !$past(tgt_data[7]));

    // R7
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !busy && hold_any) |=> !use_array);

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_any && !(exit_cmd && !busy)) |=> hold_any);

    // R9
    outside_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy && suspended && op_erase &&
         rd_addr[ADDR_W-1:SECT_LSB] != tgt_addr[ADDR_W-1:SECT_LSB])
        |=> use_array && status_out == 8'h00);
endmodule

bind flashstat_gen flashstat_gen_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
    .suspended(suspended), .poll_mode(poll_mode), .exit_cmd(exit_cmd),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .tgt_addr(tgt_addr),
    .tgt_data(tgt_data), .status_out(status_out), .use_array(use_array),
    .hold_any(hold_any)
);

// File: tb/flashstat_gen_test.sv
module flashstat_gen_test;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int SL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 0, op_erase = 0, suspended = 0, poll_mode = 0;
    logic err_limit = 0, err_protect = 0, prog_start = 0, vpp_low = 0;
    logic exit_cmd = 0, rd_strobe = 0;
    logic [DW-1:0] old_word = '1, tgt_data = '0;
    logic [AW-1:0] rd_addr = '0, tgt_addr = '0;
    logic [7:0] status_out;
    logic use_array;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    // Reference state
    bit m_f5, m_f3, m_dn, m_t6, m_t2, m_use;
    logic [7:0] m_st;

    always #2 clk = !clk;

    flashstat_gen #(.ADDR_W(AW), .DATA_W(DW), .SECT_LSB(SL)) uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .suspended(suspended), .poll_mode(poll_mode), .err_limit(err_limit),
        .err_protect(err_protect), .prog_start(prog_start), .old_word(old_word),
        .vpp_low(vpp_low), .exit_cmd(exit_cmd), .rd_strobe(rd_strobe),
        .rd_addr(rd_addr), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .status_out(status_out), .use_array(use_array)
    );

    function automatic bit f_shown();
        bit hit = op_erase ? (rd_addr[AW-1:SL] == tgt_addr[AW-1:SL]) : (rd_addr == tgt_addr);
        if (busy) return !suspended || hit;
        return m_f5 || m_f3 || m_dn;
    endfunction

    function automatic logic [7:0] f_word();
        logic [7:0] w = 8'h00;
        bit dp = op_erase ? 1'b0 : !tgt_data[7];
        if (!f_shown()) return w;
        w[5] = m_f5; w[3] = m_f3;
        if (busy && !suspended) begin
            w[7] = poll_mode ? 1'b0 : dp; w[6] = m_t6; w[2] = op_erase ? m_t2 : 1'b1;
        end else if (busy) begin
            w[7] = 1'b1; w[6] = 1'b1; w[2] = op_erase ? m_t2 : 1'b1;
        end else begin
            w[7] = poll_mode ? 1'b1 : dp; w[6] = m_t6; w[2] = m_t2;
        end
        return w;
    endfunction

    // Reference update at each rising edge from the driven inputs.
    always @(posedge clk) begin
        bit clr, s5;
        if (!rst_n) begin
            m_f5 = 0; m_f3 = 0; m_dn = 0; m_t6 = 0; m_t2 = 0; m_st = 8'h00; m_use = 1;
        end else begin
            if (rd_strobe) begin
                m_st = f_word(); m_use = !f_shown();
                if (busy && !suspended) m_t6 = !m_t6;
                if (busy && op_erase && rd_addr[AW-1:SL] == tgt_addr[AW-1:SL]) m_t2 = !m_t2;
            end
            clr = exit_cmd && !busy;
            s5 = (busy && (err_limit || err_protect)) ||
                 (prog_start && !op_erase && (|(~old_word & tgt_data)));
            m_f5 = (m_f5 && !clr) || s5;
            m_f3 = (m_f3 && !clr) || (busy && vpp_low);
            m_dn = (m_dn && !clr) || (busy && poll_mode);
        end
    end

    task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [AW-1:0] a);
        rd_addr = a; rd_strobe = 1;
        cyc();
        rd_strobe = 0;
    endtask

    task automatic do_exit();
        exit_cmd = 1; cyc(); exit_cmd = 0;
    endtask

    initial begin
        #800000;
        if (!done_flag) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'd1234));
        repeat (3) cyc();
        rst_n = 1; cyc();
        chk("R1 reset", {use_array, status_out}, {1'b1, 8'h00});

        // Program, poll_mode 0
        busy = 1; op_erase = 0; tgt_addr = 12'h123; tgt_data = 16'h0080;
        rd(12'h123); chk("R2 program inv bit7", {use_array, status_out}, {1'b0, 8'h04});
        rd(12'h123); chk("R4 toggle", {use_array, status_out}, {1'b0, 8'h44});
        rd(12'h123); chk("R10 program bit2", {use_array, status_out}, {1'b0, 8'h04});
        tgt_data = 16'h0000;
        rd(12'h123); chk("R2 program bit7", {use_array, status_out}, {1'b0, 8'hC4});
        chk("R11 zero bits", {1'b0, status_out & 8'h13}, 9'h000);
        keep = status_out;
        tgt_data = 16'h5555; busy = 0; cyc(); cyc();
        chk("R12 no strobe", {use_array, status_out}, {1'b0, keep});
        rd(12'h000); chk("R8 auto return", {use_array, status_out}, {1'b1, 8'h00});

        // Erase, poll_mode 0
        busy = 1; op_erase = 1; tgt_addr = 12'h3A0;
        rd(12'h355); chk("R2 erase bit7", {use_array, status_out}, {1'b0, 8'h00});
        rd(12'h312); chk("R10 erase toggle", {use_array, status_out}, {1'b0, 8'h44});
        suspended = 1;
        rd(12'h3FF); chk("R9 suspended in sector", {use_array, status_out}, {1'b0, 8'hC0});
        rd(12'h3FF); chk("R10 suspended toggle", {use_array, status_out}, {1'b0, 8'hC4});
        rd(12'h400); chk("R9 outside sector", {use_array, status_out}, {1'b1, 8'h00});

        // Resume with poll_mode 1
        suspended = 0; poll_mode = 1;
        rd(12'h300); chk("R3 running bit7", {use_array, status_out[7]}, 9'h000);
        busy = 0; cyc();
        rd(12'h000); chk("R3 held bit7", {use_array, status_out}, {1'b0, 8'hC4});
        rd(12'h000); chk("R4 stopped", {use_array, status_out}, {1'b0, 8'hC4});
        do_exit();
        rd(12'h000); chk("R8 exit after success", {use_array, status_out}, {1'b1, 8'h00});

        // Failure hold and exit while busy
        poll_mode = 0; op_erase = 0; busy = 1;
        err_protect = 1; cyc(); err_protect = 0; busy = 0; cyc();
        rd(12'h001); chk("R5 protect sets bit5", {use_array, status_out[5]}, 9'h001);
        busy = 1; do_exit(); busy = 0; cyc();
        rd(12'h001); chk("R7 exit while busy", {use_array, status_out[5]}, 9'h001);
        do_exit();
        rd(12'h001); chk("R7 exit idle", {use_array, status_out}, {1'b1, 8'h00});

        // Supply low
        busy = 1; vpp_low = 1; cyc(); vpp_low = 0; busy = 0; cyc();
        rd(12'h002); chk("R6 supply bit3", {use_array, status_out[3]}, 9'h001);
        do_exit();

        // Raising a cleared bit
        busy = 1; prog_start = 1; old_word = 16'h00F0; tgt_data = 16'h0100;
        cyc(); prog_start = 0;
        rd(12'h050); chk("R5 illegal raise", {use_array, status_out[5]}, 9'h001);
        busy = 0; do_exit();
        busy = 1; prog_start = 1; old_word = 16'hFFFF; tgt_data = 16'h1234;
        cyc(); prog_start = 0;
        rd(12'h050); chk("R5 legal program", {use_array, status_out[5]}, 9'h000);
        busy = 0; cyc();
        err_limit = 1; cyc(); err_limit = 0;
        rd(12'h050); chk("R5 idle error ignored", {use_array, status_out}, {1'b1, 8'h00});

        // Random phase against the reference
        for (int i = 0; i < 4000; i++) begin
            busy        = ($urandom % 8) != 0;
            op_erase    = $urandom % 2;
            suspended   = ($urandom % 4) == 0;
            poll_mode   = ($urandom % 3) == 0;
            err_limit   = ($urandom % 60) == 0;
            err_protect = ($urandom % 60) == 0;
            vpp_low     = ($urandom % 60) == 0;
            prog_start  = ($urandom % 40) == 0;
            old_word    = DW'($urandom) | 16'hFF00;
            exit_cmd    = ($urandom % 6) == 0;
            rd_strobe   = ($urandom % 2) == 0;
            rd_addr     = AW'($urandom) & 12'h3FF;
            tgt_addr    = AW'($urandom) & 12'h3FF;
            tgt_data    = DW'($urandom);
            cyc();
            chk("R12 model", {use_array, status_out}, {m_use, m_st});
        end
        rd_strobe = 0; exit_cmd = 0;

        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule